// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Multi-Page Write Cache

This block makes a 4096 x 8 internal register array answer on a two-wire I2C bus as a serial EEPROM. The block oversamples SCL and SDA with the system clock, finds START and STOP conditions and shifts bytes in and out. It drives SDA only through an open-drain pull-down enable. Three strap inputs select which of up to eight devices on the bus it is.

A write load is a write control byte followed by a high address byte, a low address byte and any number of data bytes. The data bytes go into a 64-byte cache arranged as eight lines of eight bytes. The array itself is not touched until a STOP ends the load on a byte boundary. At that point the whole cache is copied into the array inside one self-timed busy interval. During that interval every control byte is refused. Reads come in three kinds. A current-address read uses the internal address counter. A random read loads the counter with a dummy write and then issues a repeated START. A sequential read keeps going for as long as the master acknowledges.

Top module: `twi_eeprom`

## Requirements
- R1: After reset, sda_oe is 0, the block is not busy, and the first matching control byte is acknowledged.
- R2: A control byte is acknowledged (SDA pulled low in the ninth clock) only when bits 7..4 are 1010 and bits 3..1 equal strap_sel. Bit 0 is 1 for read and 0 for write. On a mismatch the block leaves SDA released and ignores the bus until the next START.
- R3: While a write cycle is in progress, a control byte that otherwise matches is not acknowledged.
- R4: After a write control byte, the next two bytes form the 12-bit word address with the high byte first. Bits 7..4 of the high byte have no effect.
- R5: A load of one data byte followed by STOP stores that byte at the word address once the write cycle ends.
- R6: In a load starting at word address A, data byte n (counted from 0) lands on page (A[11:3] + n[5:3]) mod 512 at offset (A[2:0] + n[2:0]) mod 8. The low three bits wrap inside a page, and every eight bytes move on to the next page and cache line.
- R7: Byte n and byte n+64 of one load occupy the same cache slot. The later byte is the one written.
- R8: The load is discarded and no write cycle starts if a STOP or START arrives partway through a data byte, or if a repeated START follows the data bytes. The next control byte is then acknowledged at once.
- R9: A STOP that follows at least one complete data byte starts a write cycle. The cycle lasts TWR_CYCLES clocks (TWR_CYCLES is at least 64), and control bytes are acknowledged again afterwards.
- R10: A current-address read returns the byte at the address counter. A write load leaves the counter at its word address, and each byte read advances it by one.
- R11: A random read returns the byte at the word address given in the preceding dummy write.
- R12: A sequential read returns consecutive addresses, and the address after 4095 is 0.
- R13: After the master answers a read byte with NACK, the block keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_sel | input | 3 | Device select straps |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Write loads are tried in several forms: a single byte, a load starting in the middle of a page so that it wraps and spills across three pages, and a 70-byte load that overruns the cache. Comparing these against a per-byte placement model separates the in-page wrap, the step to the next line and the cache overrun from one another. Reads are tried as random, current-address and sequential reads, including one that crosses from 4095 to 0. Aborted loads (a STOP or START partway through a byte, or a repeated START after the data) are told apart from committed ones by whether the next control byte is acknowledged and by the data read back. Randomly placed loads of random length, made with a fixed seed, exercise the placement rule at arbitrary offsets.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package eep_pkg;

    // Fixed device code expected in the top nibble of a control byte.
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for START
        ST_CTRL,   // shifting in the control byte
        ST_AHI,    // shifting in the high word-address byte
        ST_ALO,    // shifting in the low word-address byte
        ST_WDAT,   // shifting in write data bytes
        ST_ACK,    // slave driving ACK in the ninth clock
        ST_RDAT,   // slave shifting out a read byte
        ST_MACK    // master answering a read byte
    } ctrl_state_t;

endpackage

// File: rtl/eep_line_sync.sv
// Synchroniser and bus event detector.
// Brings SCL and SDA into the clock domain through a flop chain and flags
// SCL edges and START/STOP. Assumes at least two stages and that SDA and
// SCL never change within the same few system clocks.
module eep_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d, scl_s;

    // Shift the raw lines through the synchroniser chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s = scl_q[SYNC_STAGES-1];
    assign sda_s = sda_q[SYNC_STAGES-1];

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eep_ctrl.sv
// Bus protocol engine.
// Receives control, address and data bytes, drives ACK and read data, keeps
// the address counter and tells the cache and the store what to do.
// Assumes the event strobes from eep_line_sync and a registered read port.
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic              busy,
    input  logic              cache_has_data,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cache_clear,
    output logic              cache_push,
    output logic [7:0]        push_data,
    output logic [ADDR_W-1:0] load_base,
    output logic              start_commit
);

    localparam int HI_W = ADDR_W - 8;

    ctrl_state_t       st, nxt;
    logic [3:0]        bitcnt;
    logic [7:0]        sh, tx;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] cur_addr;
    logic              drv, mack;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        cache_clear  <= 1'b0;
        cache_push   <= 1'b0;
        start_commit <= 1'b0;
        if (!rst_n) begin
            st        <= ST_IDLE;
            nxt       <= ST_IDLE;
            bitcnt    <= '0;
            sh        <= '0;
            tx        <= '0;
            addr_hi   <= '0;
            cur_addr  <= '0;
            load_base <= '0;
            push_data <= '0;
            drv       <= 1'b0;
            mack      <= 1'b0;
        end else if (start_det) begin
            if (st == ST_WDAT) cache_clear <= 1'b1;
            st     <= ST_CTRL;
            bitcnt <= '0;
            drv    <= 1'b0;
        end else if (stop_det) begin
            if (st == ST_WDAT) begin
                // One rise is the STOP clock itself; more means a cut byte.
                if (bitcnt <= 4'd1 && cache_has_data) start_commit <= 1'b1;
                else cache_clear <= 1'b1;
            end
            st  <= ST_IDLE;
            drv <= 1'b0;
        end else begin
            case (st)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        case (st)
                            ST_CTRL: begin
                                if (sh[7:4] == DEV_CODE && sh[3:1] == strap && !busy) begin
                                    drv <= 1'b1;
                                    st  <= ST_ACK;
                                    if (sh[0]) begin
                                        nxt <= ST_RDAT;
                                    end else begin
                                        nxt         <= ST_AHI;
                                        cache_clear <= 1'b1;
                                    end
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                addr_hi <= sh[HI_W-1:0];
                                drv     <= 1'b1;
                                st      <= ST_ACK;
                                nxt     <= ST_ALO;
                            end
                            ST_ALO: begin
                                cur_addr  <= {addr_hi, sh};
                                load_base <= {addr_hi, sh};
                                drv       <= 1'b1;
                                st        <= ST_ACK;
                                nxt       <= ST_WDAT;
                            end
                            default: begin
                                cache_push <= 1'b1;
                                push_data  <= sh;
                                drv        <= 1'b1;
                                st         <= ST_ACK;
                                nxt        <= ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        st     <= nxt;
                        if (nxt == ST_RDAT) begin
                            tx       <= rd_data;
                            drv      <= ~rd_data[7];
                            cur_addr <= cur_addr + ADDR_W'(1);
                        end else begin
                            drv <= 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            drv <= 1'b0;
                            st  <= ST_MACK;
                        end else begin
                            drv <= ~tx[6];
                            tx  <= {tx[6:0], 1'b0};
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (mack) begin
                            tx       <= rd_data;
                            drv      <= ~rd_data[7];
                            cur_addr <= cur_addr + ADDR_W'(1);
                            st       <= ST_RDAT;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe  = drv;
    assign rd_addr = cur_addr;

    // R13
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != $past(drv)) |-> $past(scl_fall || start_det || stop_det));

    // R12
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MACK && scl_fall && mack && !start_det && !stop_det)
            |=> rd_addr == $past(rd_addr) + ADDR_W'(1));

endmodule

// File: rtl/eep_cache.sv
// Write-load cache.
// Holds 2**LINE_W lines of 2**PAGE_W bytes with a valid bit per byte. Bytes
// fill lines in arrival order; the in-line slot is offset by the load's
// start offset and wraps in the line. Assumes it is cleared before each load.
module eep_cache #(
    parameter int LINE_W = 3,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     push,
    input  logic [7:0]               push_data,
    input  logic [PAGE_W-1:0]        base_off,
    input  logic                     busy,
    input  logic [LINE_W+PAGE_W-1:0] scan_idx,
    output logic [7:0]               scan_data,
    output logic                     scan_valid,
    output logic                     has_data
);

    localparam int IDX_W   = LINE_W + PAGE_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]   wr_cnt;
    logic [IDX_W-1:0]   wr_idx;
    logic [ENTRIES-1:0] valid_vec;
    logic [7:0]         data_arr [ENTRIES];

    // Arrival counter; wraps after a full cache so later bytes overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) wr_cnt <= '0;
        else if (push)       wr_cnt <= wr_cnt + IDX_W'(1);
    end

    assign wr_idx = {wr_cnt[IDX_W-1:PAGE_W], wr_cnt[PAGE_W-1:0] + base_off};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic       v_q;
        logic [7:0] d_q;
        // One cache slot: capture on a push that targets it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (push && wr_idx == IDX_W'(e)) begin
                v_q <= 1'b1;
                d_q <= push_data;
            end
        end
        assign valid_vec[e] = v_q;
        assign data_arr[e]  = d_q;
    end

    assign scan_data  = data_arr[scan_idx];
    assign scan_valid = valid_vec[scan_idx];
    assign has_data   = |valid_vec;

    // R3
    push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !clear);

endmodule

// File: rtl/eep_store.sv
// Storage array and timed commit engine.
// On start_commit it walks every cache slot once, writes the valid ones to
// the array, and stays busy for TWR_CYCLES clocks or until the walk ends,
// whichever is later. The read port is registered every clock.
module eep_store #(
    parameter int ADDR_W     = 12,
    parameter int LINE_W     = 3,
    parameter int PAGE_W     = 3,
    parameter int TWR_CYCLES = 200000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_commit,
    input  logic [ADDR_W-PAGE_W-1:0] base_page,
    output logic [LINE_W+PAGE_W-1:0] scan_idx,
    input  logic [7:0]               scan_data,
    input  logic                     scan_valid,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int IDX_W = LINE_W + PAGE_W;
    localparam int PG_W  = ADDR_W - PAGE_W;
    localparam int TW    = $clog2(TWR_CYCLES + 1);

    logic [7:0]        arr [DEPTH];
    logic [TW-1:0]     timer;
    logic              scanning;
    logic [PG_W-1:0]   page_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    // Commit sequencer: slot walk plus minimum busy time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            scanning <= 1'b0;
            scan_idx <= '0;
            timer    <= '0;
            page_q   <= '0;
        end else if (start_commit) begin
            busy     <= 1'b1;
            scanning <= 1'b1;
            scan_idx <= '0;
            timer    <= '0;
            page_q   <= base_page;
        end else if (busy) begin
            if (timer < TW'(TWR_CYCLES)) timer <= timer + TW'(1);
            if (scanning) begin
                scan_idx <= scan_idx + IDX_W'(1);
                if (scan_idx == '1) scanning <= 1'b0;
            end
            if (timer >= TW'(TWR_CYCLES - 1) && !scanning) busy <= 1'b0;
        end
    end

    assign wr_en   = busy && scanning && scan_valid;
    assign wr_addr = {page_q + PG_W'(scan_idx[IDX_W-1:PAGE_W]), scan_idx[PAGE_W-1:0]};

    // Array write from the walk and registered read for the bus engine.
    always_ff @(posedge clk) begin
        if (wr_en) arr[wr_addr] <= scan_data;
        rd_data <= arr[rd_addr];
    end

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_commit |-> !busy);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_commit));

endmodule

// File: rtl/twi_eeprom.sv
// Serial EEPROM slave top level.
// Wires the line synchroniser, protocol engine, write cache and storage.
// Assumes the system clock is at least about 8x faster than the quarter
// period of SCL and that sda_oe drives an open-drain pull-down.
module twi_eeprom #(
    parameter int ADDR_W      = 12,
    parameter int LINE_W      = 3,
    parameter int PAGE_W      = 3,
    parameter int TWR_CYCLES  = 200000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_sel,
    output logic       sda_oe
);

    localparam int IDX_W = LINE_W + PAGE_W;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, has_data, cache_clear, cache_push, start_commit;
    logic              scan_valid;
    logic [7:0]        push_data, scan_data, rd_data;
    logic [ADDR_W-1:0] rd_addr, load_base;
    logic [IDX_W-1:0]  scan_idx;

    eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .strap(strap_sel), .busy(busy), .cache_has_data(has_data),
        .rd_data(rd_data), .sda_oe(sda_oe), .rd_addr(rd_addr),
        .cache_clear(cache_clear), .cache_push(cache_push),
        .push_data(push_data), .load_base(load_base),
        .start_commit(start_commit)
    );

    eep_cache #(.LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .clear(cache_clear), .push(cache_push),
        .push_data(push_data), .base_off(load_base[PAGE_W-1:0]),
        .busy(busy), .scan_idx(scan_idx), .scan_data(scan_data),
        .scan_valid(scan_valid), .has_data(has_data)
    );

    eep_store #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W),
        .TWR_CYCLES(TWR_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .start_commit(start_commit),
        .base_page(load_base[ADDR_W-1:PAGE_W]), .scan_idx(scan_idx),
        .scan_data(scan_data), .scan_valid(scan_valid),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

endmodule

// File: tb/twi_eeprom_tb.sv
// Self-checking bench: bus master tasks plus a byte-placement model.
module twi_eeprom_tb;

    localparam int TWR = 400;
    localparam int Q   = 5;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl, m_sda;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mdl   [4096];
    logic        known [4096];
    logic [7:0]  wbuf  [80];
    logic [11:0] cur_exp;

    always #5 clk = ~clk;

    twi_eeprom #(.TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .strap_sel(STRAP), .sda_oe(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] place(input logic [11:0] base, input int n);
        logic [8:0] pg;
        logic [2:0] off;
        pg  = base[11:3] + 9'(n / 8 % 8);
        off = base[2:0] + 3'(n % 8);
        return {pg, off};
    endfunction

    function automatic logic [7:0] ctl(input logic [2:0] sel, input bit rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b0; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; tick(Q);
            m_scl = 1'b1;   tick(2*Q);
            m_scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    // Write load of n bytes from wbuf; model updated in arrival order.
    task automatic do_write(input logic [11:0] addr, input int n, input bit wait_done, input string req);
        bit a, all_ok;
        logic [3:0] junk;
        all_ok = 1'b1;
        junk = 4'($urandom);
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a); all_ok &= a;
        send_byte({junk, addr[11:8]}, a); all_ok &= a;
        send_byte(addr[7:0], a); all_ok &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ok &= a;
            mdl[place(addr, i)]   = wbuf[i];
            known[place(addr, i)] = 1'b1;
        end
        bus_stop();
        chk(all_ok, req, int'(all_ok), 1);
        cur_exp = addr;
        if (wait_done) tick(TWR + 200);
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            if (known[cur_exp]) chk(b == mdl[cur_exp], req, b, mdl[cur_exp]);
            cur_exp = cur_exp + 12'd1;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [11:0] addr, input int n, input string req);
        bit a;
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        send_byte({4'h0, addr[11:8]}, a);
        send_byte(addr[7:0], a);
        bus_start();
        send_byte(ctl(STRAP, 1'b1), a);
        chk(a, req, int'(a), 1);
        cur_exp = addr;
        read_bytes(n, req);
    endtask

    task automatic probe_ack(output bit a);
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        bus_stop();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        logic [11:0] ra;
        int n;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4096; i++) known[i] = 1'b0;
        m_scl = 1'b1;
        m_sda = 1'b1;
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: idle after reset and immediately addressable.
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        probe_ack(a);
        chk(a, "R1 first ack", a, 1);

        // R2: wrong straps, wrong device code, then following byte ignored.
        bus_start();
        send_byte(ctl(3'b011, 1'b0), a);
        chk(!a, "R2 strap mismatch", a, 0);
        send_byte(ctl(STRAP, 1'b0), a);
        chk(!a, "R2 ignored until START", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, a);
        chk(!a, "R2 code mismatch", a, 0);
        bus_stop();

        // R4 R5 R3 R9: byte write with junk high nibble, busy then free.
        wbuf[0] = 8'h3C;
        do_write(12'h123, 1, 1'b0, "R5 load acks");
        probe_ack(a);
        chk(!a, "R3 nack while busy", a, 0);
        tick(TWR + 200);
        probe_ack(a);
        chk(a, "R9 ack after cycle", a, 1);
        rand_read(12'h123, 1, "R4 R11 byte read");

        // R13: master NACK, then slave keeps SDA released.
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        send_byte(8'h01, a);
        send_byte(8'h23, a);
        bus_start();
        send_byte(ctl(STRAP, 1'b1), a);
        recv_byte(b, 1'b0);
        chk(b == 8'h3C, "R13 byte before nack", b, 8'h3C);
        recv_byte(b, 1'b0);
        chk(b == 8'hFF, "R13 released after nack", b, 8'hFF);
        bus_stop();

        // R6: load from mid-page spilling over three pages.
        for (int i = 0; i < 20; i++) wbuf[i] = 8'($urandom);
        do_write(12'h205, 20, 1'b1, "R6 load acks");
        bus_start();
        send_byte(ctl(STRAP, 1'b1), a);
        chk(a, "R10 current read ack", a, 1);
        read_bytes(1, "R10 current after load");
        rand_read(12'h200, 24, "R6 R12 page spill");

        // R7: 70-byte load overruns the cache.
        for (int i = 0; i < 70; i++) wbuf[i] = 8'($urandom);
        do_write(12'h3C0, 70, 1'b1, "R7 load acks");
        rand_read(12'h3C0, 16, "R7 overrun");

        // R12 R10: rollover from 4095 to 0, then current-address read.
        for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
        do_write(12'h000, 8, 1'b1, "R12 low page");
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
        do_write(12'hFFE, 2, 1'b1, "R12 top bytes");
        rand_read(12'hFFE, 4, "R12 rollover");
        bus_start();
        send_byte(ctl(STRAP, 1'b1), a);
        read_bytes(2, "R10 current continues");

        // R8: aborted loads leave memory alone and start no cycle.
        wbuf[0] = 8'h11;
        do_write(12'h050, 1, 1'b1, "R8 preload");
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        send_byte(8'h00, a);
        send_byte(8'h50, a);
        send_byte(8'hAA, a);
        send_bits(8'hA0, 3);
        bus_stop();
        probe_ack(a);
        chk(a, "R8 stop mid-byte not busy", a, 1);
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        send_byte(8'h00, a);
        send_byte(8'h50, a);
        send_bits(8'hC0, 3);
        bus_start();
        bus_stop();
        probe_ack(a);
        chk(a, "R8 start mid-byte not busy", a, 1);
        bus_start();
        send_byte(ctl(STRAP, 1'b0), a);
        send_byte(8'h00, a);
        send_byte(8'h50, a);
        send_byte(8'hBB, a);
        bus_start();
        send_byte(ctl(STRAP, 1'b1), a);
        chk(a, "R8 repeated START read ack", a, 1);
        cur_exp = 12'h050;
        read_bytes(1, "R8 R10 discarded load");
        probe_ack(a);
        chk(a, "R8 no cycle after repeated START", a, 1);
        rand_read(12'h050, 1, "R8 memory intact");

        // R6 R11: random loads at random offsets and lengths.
        for (int it = 0; it < 5; it++) begin
            ra = 12'($urandom);
            n  = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(ra, n, 1'b1, "R6 random load acks");
            rand_read({ra[11:3], 3'b000}, 16, "R6 R11 random readback");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule